// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the slave side of a 2048-bit serial memory on a three-wire bus with chip select, a serial clock, a serial data input and a serial data output. The output comes with an enable, so it can be tri-stated and tied to the data input to make one shared pin. All logic runs on a system clock `clk`. The serial inputs are sampled on that clock and must already be synchronous to it. Each rising edge of the serial clock is found by comparing the present sample with the previous one.

A parameter picks 16-bit or 8-bit words (128 or 256 words). A second parameter adds one don't-care address bit for the longer-address variant. The block stores its contents in an internal register array. It decodes seven commands: read, word write, word erase, fill-all, clear-all, unlock and lock. A write-class command starts a self-timed programming interval when chip select falls. That interval lasts `WRITE_CYCLES` clocks, and the device reports its progress on the output pin. After reset, a hold-off counter of `PWRUP_CYCLES` clocks makes the device deaf to all bus activity.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads all ones, writes are locked and `dout_oe` is low. For `PWRUP_CYCLES` clocks after reset all serial activity is ignored and `dout_oe` stays low.
- R2: A frame starts with a '1' on `di`, sampled at a rising `sk` edge while `cs` is high. Zeros before it are ignored. Next come a 2-bit opcode and AW address bits, MSB first. AW is 7 for 16-bit words and 8 for 8-bit words, plus 1 when ADDR_WIDE=1. Only the low log2(depth) address bits select the word.
- R3: Opcode 10 is a read. The `sk` rise that samples the last address bit drives a dummy '0' on `dout`. Each later rise drives the next word bit, MSB first.
- R4: If `sk` keeps running during a read, the words at the following addresses are sent back to back with no dummy bit. The address wraps from the last word to word 0.
- R5: With opcode 00, address bits [AW-1:AW-2] act as a sub-code. 11 unlocks writes and 00 locks them. While locked, every write-class command leaves the memory unchanged and starts no busy interval.
- R6: Opcode 01 followed by one word of data, MSB first, writes that word. Opcode 11 sets the addressed word to all ones. Either one takes effect when `cs` falls.
- R7: Sub-code 01 followed by one data word writes that value to every word. Sub-code 10 sets every word to all ones.
- R8: A write-class frame is dropped with no memory change and no busy interval in two cases: `cs` falls before the frame is complete, or one more `sk` rise comes after it is complete.
- R9: A committed command makes the device busy for `WRITE_CYCLES` clocks, starting at the clock after `cs` falls. While busy, frames are ignored. Whenever `cs` is high, `dout` reads 0 during the interval and 1 after it.
- R10: While status is shown, an `sk` rise with `di`=1 turns `dout_oe` off. If the device is ready, that same bit also counts as the start bit of the next frame.
- R11: `dout_oe` is low whenever `cs` is low. It is high only while read data or status is being shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (read data or ready/busy) |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
Every word gets its own pattern, and all 128 words are read back in one continuous burst that runs past the last word. A design that forgot the dummy bit, reloaded words one bit late, or failed to wrap would shift or corrupt the stream. The bench issues frames while writes are locked, during the hold-off window and during a busy interval. It also sends frames that are cut short or carry an extra bit. A design that committed any of these would show a changed word or an unexpected status output. The busy interval is timed from the fall of `cs` to the first ready reading, so an off-by-one timer is exposed. The release bit must turn off the output on that very edge.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RD,
        ST_HOLD,
        ST_DROP
    } mw_state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_FILL,
        CMD_CLEAR
    } mw_cmd_e;

    // pending write-class action captured at end of header
    typedef struct packed {
        logic all;
        logic erase;
    } mw_pend_t;

    typedef struct packed {
        logic valid;
        logic all;
        logic erase;
    } mw_commit_t;

    function automatic mw_cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sub);
        mw_cmd_e c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (sub)
                    2'b11:   c = CMD_UNLOCK;
                    2'b00:   c = CMD_LOCK;
                    2'b10:   c = CMD_CLEAR;
                    default: c = CMD_FILL;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mw_pins.sv
module mw_pins (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    output logic sk_rise,
    output logic cs_fall
);
    logic cs_q;
    logic sk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    assign sk_rise = cs & sk & ~sk_q;
    assign cs_fall = cs_q & ~cs;
endmodule

// File: rtl/mw_timers.sv
module mw_timers #(
    parameter int WRITE_CYCLES = 2000,
    parameter int PWRUP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pwr_ok,
    output logic busy
);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);
    localparam int WB = $clog2(WRITE_CYCLES + 1);

    logic [PW-1:0] pcnt;
    logic [WB-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (pcnt != PW'(PWRUP_CYCLES)) begin
            pcnt <= pcnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (start) begin
            wcnt <= WB'(WRITE_CYCLES);
        end else if (wcnt != '0) begin
            wcnt <= wcnt - WB'(1);
        end
    end

    assign pwr_ok = (pcnt == PW'(PWRUP_CYCLES));
    assign busy   = (wcnt != '0);
endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  mw_commit_t    cmt,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (cmt.valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmt.all || (waddr == IW'(i))) begin
                    mem[i] <= cmt.erase ? '1 : wdata;
                end
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORD16       = 1,
    parameter int ADDR_WIDE    = 0,
    parameter int WRITE_CYCLES = 2000,
    parameter int PWRUP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    localparam int DW    = (WORD16 != 0) ? 16 : 8;
    localparam int DEPTH = 2048 / DW;
    localparam int IW    = $clog2(DEPTH);
    localparam int AW    = IW + ADDR_WIDE;
    localparam int HW    = AW + 2;
    localparam int CMAX  = (HW > DW) ? HW : DW;
    localparam int CW    = $clog2(CMAX + 1);

    logic sk_rise, cs_fall, pwr_ok, busy;

    mw_state_e     st;
    logic [HW-1:0] hdr;
    logic [HW-1:0] hdr_n;
    logic [CW-1:0] cnt;
    logic [DW-1:0] wbuf;
    logic [IW-1:0] waddr;
    logic [IW-1:0] rd_addr;
    logic [IW-1:0] raddr;
    logic [DW-1:0] rd_sr;
    logic [DW-1:0] rdata;
    logic          rd_bit;
    logic          wr_en;
    logic          stat_pend;
    mw_pend_t      pend;
    mw_commit_t    cmt;
    mw_cmd_e       cmd;

    mw_pins u_pins (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk),
        .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_timers #(.WRITE_CYCLES(WRITE_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(cmt.valid),
        .pwr_ok(pwr_ok), .busy(busy)
    );

    mw_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .cmt(cmt), .waddr(waddr),
        .wdata(wbuf), .raddr(raddr), .rdata(rdata)
    );

    assign hdr_n = {hdr[HW-2:0], di};
    assign cmd   = decode_cmd(hdr_n[HW-1:HW-2], hdr_n[AW-1:AW-2]);
    assign raddr = (st == ST_RD) ? (rd_addr + IW'(1)) : hdr_n[IW-1:0];

    always_comb begin
        cmt.valid = pwr_ok && cs_fall && (st == ST_HOLD) && wr_en;
        cmt.all   = pend.all;
        cmt.erase = pend.erase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            hdr       <= '0;
            cnt       <= '0;
            wbuf      <= '0;
            waddr     <= '0;
            rd_addr   <= '0;
            rd_sr     <= '0;
            rd_bit    <= 1'b0;
            wr_en     <= 1'b0;
            stat_pend <= 1'b0;
            pend      <= '0;
        end else if (!pwr_ok) begin
            st <= ST_IDLE;
        end else if (!cs) begin
            st <= ST_IDLE;
            if (cmt.valid) stat_pend <= 1'b1;
        end else if (sk_rise) begin
            unique case (st)
                ST_IDLE: begin
                    if (di) begin
                        stat_pend <= 1'b0;
                        if (!busy) begin
                            st  <= ST_HDR;
                            cnt <= '0;
                        end
                    end
                end
                ST_HDR: begin
                    hdr <= hdr_n;
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(HW - 1)) begin
                        cnt   <= '0;
                        waddr <= hdr_n[IW-1:0];
                        unique case (cmd)
                            CMD_READ: begin
                                st      <= ST_RD;
                                rd_addr <= hdr_n[IW-1:0];
                                rd_sr   <= rdata;
                                rd_bit  <= 1'b0;
                            end
                            CMD_WRITE: begin
                                st   <= ST_WDATA;
                                pend <= '{all: 1'b0, erase: 1'b0};
                            end
                            CMD_ERASE: begin
                                st   <= ST_HOLD;
                                pend <= '{all: 1'b0, erase: 1'b1};
                            end
                            CMD_FILL: begin
                                st   <= ST_WDATA;
                                pend <= '{all: 1'b1, erase: 1'b0};
                            end
                            CMD_CLEAR: begin
                                st   <= ST_HOLD;
                                pend <= '{all: 1'b1, erase: 1'b1};
                            end
                            CMD_UNLOCK: begin
                                st    <= ST_DROP;
                                wr_en <= 1'b1;
                            end
                            default: begin
                                st    <= ST_DROP;
                                wr_en <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_WDATA: begin
                    wbuf <= {wbuf[DW-2:0], di};
                    cnt  <= cnt + CW'(1);
                    if (cnt == CW'(DW - 1)) begin
                        cnt <= '0;
                        st  <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    st <= ST_DROP;
                end
                ST_RD: begin
                    rd_bit <= rd_sr[DW-1];
                    if (cnt == CW'(DW - 1)) begin
                        cnt     <= '0;
                        rd_sr   <= rdata;
                        rd_addr <= rd_addr + IW'(1);
                    end else begin
                        cnt   <= cnt + CW'(1);
                        rd_sr <= {rd_sr[DW-2:0], 1'b0};
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign dout_oe = cs && pwr_ok && ((st == ST_RD) || stat_pend);
    assign dout    = dout_oe && ((st == ST_RD) ? rd_bit : !busy);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
#(
    parameter int WRITE_CYCLES = 2000,
    parameter int PWRUP_CYCLES = 1000
) (
    input logic      clk,
    input logic      rst,
    input logic      cs,
    input logic      sk,
    input logic      di,
    input logic      dout,
    input logic      dout_oe,
    input logic      busy,
    input mw_state_e st
);
    localparam int PC = $clog2(PWRUP_CYCLES + 1);
    localparam int BC = $clog2(WRITE_CYCLES + 2);

    logic [PC-1:0] since_rst;
    logic [BC-1:0] blen;
    logic          sk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            blen      <= '0;
            sk_prev   <= 1'b0;
        end else begin
            sk_prev <= sk;
            if (since_rst != PC'(PWRUP_CYCLES)) since_rst <= since_rst + PC'(1);
            if (busy) blen <= blen + BC'(1);
            else      blen <= '0;
        end
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !dout_oe); // R11

    AST_QUIET_AT_POWERUP: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PC'(PWRUP_CYCLES)) |-> !dout_oe); // R1

    AST_BUSY_AFTER_CS_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!$past(cs) && $past(cs, 2))); // R9

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen == BC'(WRITE_CYCLES))); // R9

    AST_STATUS_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && busy) |-> !dout); // R9

    AST_RELEASE_ON_ONE: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && (st == ST_IDLE) && sk && !sk_prev && di) |=> !dout_oe); // R10

    AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_RD) && ($past(st) != ST_RD)) |-> !dout); // R3
endmodule

bind mw_eeprom mw_eeprom_chk #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .PWRUP_CYCLES(PWRUP_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .st(st)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 3;
    localparam int WCYC       = 300;
    localparam int PCYC       = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs  = 1'b0;
    logic sk  = 1'b0;
    logic di  = 1'b0;
    logic dout, dout_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] model [128];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_eeprom #(.WORD16(1), .ADDR_WIDE(0), .WRITE_CYCLES(WCYC), .PWRUP_CYCLES(PCYC)) uut (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sbit(input logic d, output logic q, output logic oe);
        @(negedge clk);
        di = d;
        sk = 1'b1;
        repeat (H) @(negedge clk);
        sk = 1'b0;
        repeat (H) @(negedge clk);
        q  = dout;
        oe = dout_oe;
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a, output logic q, output logic oe);
        sbit(1'b1, q, oe);
        sbit(op[1], q, oe);
        sbit(op[0], q, oe);
        for (int i = 6; i >= 0; i--) sbit(a[i], q, oe);
    endtask

    task automatic send_word(input logic [15:0] d);
        logic q, oe;
        for (int i = 15; i >= 0; i--) sbit(d[i], q, oe);
    endtask

    task automatic cs_up();
        @(negedge clk);
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        cs = 1'b0;
        di = 1'b0;
    endtask

    // called right after cs_down; checks status behaviour
    task automatic finish(input string req, input bit expect_busy);
        logic q, oe;
        int n;
        @(negedge clk);
        cs = 1'b1;
        @(negedge clk);
        if (!expect_busy) begin
            chk(req, {31'b0, dout_oe}, 32'h0);
        end else begin
            chk("R9", {30'b0, dout_oe, dout}, 32'h2);
            n = 2;
            while (dout !== 1'b1 && n < WCYC + 50) begin
                @(negedge clk);
                n++;
            end
            chk("R9", {31'b0, (n >= WCYC) && (n <= WCYC + 2)}, 32'h1);
            sbit(1'b1, q, oe);
            chk("R10", {31'b0, oe}, 32'h0);
        end
        cs_down();
        chk("R11", {31'b0, dout_oe}, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_check(input int a, input int n, input int lead, input string req);
        logic q, oe;
        logic [15:0] w;
        cs_up();
        for (int i = 0; i < lead; i++) sbit(1'b0, q, oe);
        send_hdr(2'b10, 7'(a), q, oe);
        chk("R3", {30'b0, oe, q}, 32'h2);
        for (int k = 0; k < n; k++) begin
            for (int b = 15; b >= 0; b--) begin
                sbit(1'b0, q, oe);
                w[b] = q;
            end
            chk(req, {16'b0, w}, {16'b0, model[(a + k) % 128]});
        end
        cs_down();
        repeat (3) @(negedge clk);
    endtask

    task automatic ctrl(input logic [1:0] sub);
        logic q, oe;
        cs_up();
        send_hdr(2'b00, {sub, 5'b0}, q, oe);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0301) ^ 16'hA55A ^ (a << 9));
    endfunction

    initial begin
        repeat (CLK_PERIOD * 190000 / CLK_PERIOD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic q, oe;
        for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11", {31'b0, dout_oe}, 32'h0);

        // R1: read attempt inside the hold-off window stays silent
        cs_up();
        send_hdr(2'b10, 7'd0, q, oe);
        chk("R1", {31'b0, oe}, 32'h0);
        sbit(1'b0, q, oe);
        chk("R1", {31'b0, oe}, 32'h0);
        cs_down();
        repeat (PCYC) @(negedge clk);

        // R1: erased contents after reset
        read_check(5, 1, 0, "R1");

        // R5: write while locked
        cs_up();
        send_hdr(2'b01, 7'd3, q, oe);
        send_word(16'h1234);
        cs_down();
        finish("R5", 1'b0);
        read_check(3, 1, 0, "R5");

        // unlock then fill every word with its own pattern
        ctrl(2'b11);
        cs_down();
        repeat (3) @(negedge clk);
        for (int a = 0; a < 128; a++) begin
            cs_up();
            send_hdr(2'b01, 7'(a), q, oe);
            send_word(pat(a));
            cs_down();
            model[a] = pat(a);
            finish("R6", 1'b1);
        end

        // R9: frame during busy is ignored
        cs_up();
        send_hdr(2'b01, 7'd40, q, oe);
        send_word(16'h0F0F);
        cs_down();
        model[40] = 16'h0F0F;
        cs_up();
        send_hdr(2'b01, 7'd41, q, oe);
        send_word(16'hDEAD);
        cs_down();
        repeat (WCYC + 20) @(negedge clk);
        read_check(40, 2, 0, "R9");

        // R3 R4: full sequential sweep with wrap to word 0
        read_check(0, 129, 0, "R4");

        // R2: leading zeros before start bit
        read_check(77, 1, 3, "R2");

        // R6: erase one word
        cs_up();
        send_hdr(2'b11, 7'd7, q, oe);
        cs_down();
        model[7] = 16'hFFFF;
        finish("R6", 1'b1);
        read_check(6, 3, 0, "R6");

        // R8: truncated write, and write with one extra bit
        cs_up();
        send_hdr(2'b01, 7'd20, q, oe);
        for (int i = 0; i < 8; i++) sbit(1'b0, q, oe);
        cs_down();
        finish("R8", 1'b0);
        cs_up();
        send_hdr(2'b01, 7'd21, q, oe);
        send_word(16'h0000);
        sbit(1'b0, q, oe);
        cs_down();
        finish("R8", 1'b0);
        read_check(20, 2, 0, "R8");

        // R5: lock, then erase is refused
        ctrl(2'b00);
        cs_down();
        repeat (3) @(negedge clk);
        cs_up();
        send_hdr(2'b11, 7'd9, q, oe);
        cs_down();
        finish("R5", 1'b0);
        read_check(9, 1, 0, "R5");

        // R7: fill-all then clear-all
        ctrl(2'b11);
        cs_down();
        repeat (3) @(negedge clk);
        ctrl(2'b01);
        send_word(16'h3C96);
        cs_down();
        for (int i = 0; i < 128; i++) model[i] = 16'h3C96;
        finish("R7", 1'b1);
        read_check(120, 16, 0, "R7");
        ctrl(2'b10);
        cs_down();
        for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
        finish("R7", 1'b1);
        read_check(0, 128, 0, "R7");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule